// File: doc/BRIEF.md
# Operate Microinstruction Unit

This block carries out the register-only "operate" instructions of a small 12-bit accumulator machine. It keeps the accumulator and the one-bit link. A single instruction word is a set of independent control bits, and each bit selects one micro-action. When a word is accepted, every selected action is applied in one clock, in a fixed order. The results are the next accumulator and link. The block also raises a skip request for the program-counter logic and a halt request.

Operate words come in two groups, chosen by one bit of the word. The first group clears, complements, increments and rotates the link-accumulator pair. The second group tests the accumulator and link for a conditional skip, clears the accumulator, ORs in the console switch value, and can request a halt. The accumulator is loaded from outside only through its own instructions, for example a clear followed by the switch OR.

Top module: `opr_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the accumulator and link are zero and the skip, halt and rotate-conflict outputs are low.
- R2: A word is accepted only on a cycle with op_valid high and op_word[11:9] equal to 3'b111. After any other cycle, the accumulator and link keep their values and skip, halt and rotate-conflict are low. All results appear in the cycle after the word is accepted.
- R3: op_word[8] selects the group: 0 means group one and 1 means group two.
- R4: Group one applies its selected actions in this order: clear accumulator (bit 7), clear link (bit 6), complement accumulator (bit 5), complement link (bit 4), increment accumulator (bit 0), then rotate. A carry out of the accumulator's top bit during the increment complements the link.
- R5: Bit 3 rotates right and bit 2 rotates left. Each rotate is a circular shift of the 13-bit value {link, accumulator}. A right rotate moves the link into the accumulator's top bit and the accumulator's bit 0 into the link. Bit 1 makes the selected rotate move two places. Bit 1 alone does nothing.
- R6: If bits 3 and 2 of a group-one word are both set, no rotate takes place, the other actions still apply, and rot_conflict_o is high for that result.
- R7: The group-two skip uses the accumulator and link from before any clear. The three conditions are: bit 6 tests for a negative accumulator (top bit set), bit 5 tests for a zero accumulator, and bit 4 tests for a link of one. With bit 3 clear, the block skips if any selected condition holds. With bit 3 set, it skips only if none of them holds, so bit 3 alone always skips.
- R8: In group two, bit 7 clears the accumulator first, and then bit 2 ORs switch_val into it. Group two never changes the link.
- R9: Group-two bit 1 raises halt_o for that result.
- R10: A group-two word with bit 0 set is reserved. It leaves the accumulator and link unchanged and raises neither skip nor halt.
- R11: Group-one words never raise skip_o or halt_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction word is present this cycle |
| op_word | input | 12 | Instruction word |
| switch_val | input | W (12) | Console switch value |
| acc_o | output | W (12) | Accumulator |
| link_o | output | 1 | Link bit |
| skip_o | output | 1 | Skip request from the last accepted word |
| halt_o | output | 1 | Halt request from the last accepted word |
| rot_conflict_o | output | 1 | Both rotate directions were requested |

## Verification
The assertions check on every cycle that idle and non-operate cycles leave the state alone and drop the flags. They also check that group one never skips or halts, that group two never touches the link, that reserved words are inert, and that halt and conflict follow their bits. They check that rotates preserve the number of ones and that a plain skip always has a selected condition behind it. The exact arithmetic can only be shown by the bench's sweeps: the ordering of clear, complement, increment and rotate, the link carry, the two-place rotates, and test-before-clear combinations. These sweeps run every group-one and group-two control pattern against several accumulator, link and switch seeds.

// File: rtl/opr_pkg.sv
package opr_pkg;
    // opcode field that marks an operate word
    localparam int          OPC_HI      = 11;
    localparam int          OPC_LO      = 9;
    localparam logic [2:0]  OPC_OPERATE = 3'b111;
    localparam int          GRP_BIT     = 8;
    localparam int          RSV_BIT     = 0;

    // group one control bits (within word bits 7..0)
    localparam int G1_CLR_ACC  = 7;
    localparam int G1_CLR_LNK  = 6;
    localparam int G1_INV_ACC  = 5;
    localparam int G1_INV_LNK  = 4;
    localparam int G1_ROT_R    = 3;
    localparam int G1_ROT_L    = 2;
    localparam int G1_TWICE    = 1;
    localparam int G1_INC      = 0;

    // group two control bits (within word bits 7..1, indexed from bit 1)
    localparam int G2_CLR_ACC  = 6;
    localparam int G2_T_NEG    = 5;
    localparam int G2_T_ZERO   = 4;
    localparam int G2_T_LINK   = 3;
    localparam int G2_INVERT   = 2;
    localparam int G2_OR_SW    = 1;
    localparam int G2_HALT     = 0;
endpackage

// File: rtl/opr_grp1.sv
module opr_grp1 import opr_pkg::*; #(
    parameter int W = 12
) (
    input  logic [7:0]   mw,
    input  logic [W-1:0] acc_i,
    input  logic         link_i,
    output logic [W-1:0] acc_o,
    output logic         link_o,
    output logic         rot_bad_o
);
    localparam int VW = W + 1;

    logic [W-1:0] a_d;
    logic         l_d;
    logic [W:0]   sum_d;
    logic [VW-1:0] pre_d;
    logic [VW-1:0] step1_d;
    logic [VW-1:0] post_d;
    logic          go_r_d;
    logic          go_l_d;

    always_comb begin
        a_d = acc_i;
        l_d = link_i;
        if (mw[G1_CLR_ACC]) a_d = '0;
        if (mw[G1_CLR_LNK]) l_d = 1'b0;
        if (mw[G1_INV_ACC]) a_d = ~a_d;
        if (mw[G1_INV_LNK]) l_d = ~l_d;
        sum_d = {1'b0, a_d} + {{W{1'b0}}, 1'b1};
        if (mw[G1_INC]) begin
            a_d = sum_d[W-1:0];
            l_d = l_d ^ sum_d[W];
        end
        pre_d  = {l_d, a_d};
        go_r_d = mw[G1_ROT_R] && !mw[G1_ROT_L];
        go_l_d = mw[G1_ROT_L] && !mw[G1_ROT_R];
        if (go_r_d)      step1_d = {pre_d[0], pre_d[VW-1:1]};
        else if (go_l_d) step1_d = {pre_d[VW-2:0], pre_d[VW-1]};
        else             step1_d = pre_d;
        if (go_r_d && mw[G1_TWICE])      post_d = {step1_d[0], step1_d[VW-1:1]};
        else if (go_l_d && mw[G1_TWICE]) post_d = {step1_d[VW-2:0], step1_d[VW-1]};
        else                             post_d = step1_d;
        acc_o     = post_d[W-1:0];
        link_o    = post_d[W];
        rot_bad_o = mw[G1_ROT_R] && mw[G1_ROT_L];
    end

    // R5: a circular shift neither creates nor loses ones
    always_comb begin
        a_rot_keeps_ones_r5 : assert ($countones(post_d) == $countones(pre_d))
            else $error("rotate changed the number of ones");
    end
endmodule

// File: rtl/opr_skip.sv
module opr_skip #(
    parameter int W = 12
) (
    input  logic [W-1:0] acc_i,
    input  logic         link_i,
    input  logic         sel_neg,
    input  logic         sel_zero,
    input  logic         sel_link,
    input  logic         invert,
    output logic         take_o
);
    logic hit_d;

    always_comb begin
        hit_d  = (sel_neg && acc_i[W-1])
              || (sel_zero && (acc_i == '0))
              || (sel_link && link_i);
        take_o = hit_d ^ invert;
    end

    // R7: a non-inverted skip needs at least one selected condition
    always_comb begin
        a_skip_needs_sel_r7 : assert (!(take_o && !invert && !(sel_neg || sel_zero || sel_link)))
            else $error("skip without a selected condition");
    end
endmodule

// File: rtl/opr_grp2.sv
module opr_grp2 import opr_pkg::*; #(
    parameter int W = 12
) (
    input  logic [7:1]   mw,
    input  logic [W-1:0] acc_i,
    input  logic         link_i,
    input  logic [W-1:0] sw_i,
    output logic [W-1:0] acc_o,
    output logic         skip_o,
    output logic         halt_o
);
    logic [6:0] b;
    logic [W-1:0] a_d;

    assign b = mw;

    // test is taken on the incoming accumulator, ahead of the clear
    opr_skip #(.W(W)) u_skip (
        .acc_i    (acc_i),
        .link_i   (link_i),
        .sel_neg  (b[G2_T_NEG]),
        .sel_zero (b[G2_T_ZERO]),
        .sel_link (b[G2_T_LINK]),
        .invert   (b[G2_INVERT]),
        .take_o   (skip_o)
    );

    always_comb begin
        a_d = acc_i;
        if (b[G2_CLR_ACC]) a_d = '0;
        if (b[G2_OR_SW])   a_d = a_d | sw_i;
        acc_o  = a_d;
        halt_o = b[G2_HALT];
    end
endmodule

// File: rtl/opr_unit.sv
module opr_unit import opr_pkg::*; #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [11:0]  op_word,
    input  logic [W-1:0] switch_val,
    output logic [W-1:0] acc_o,
    output logic         link_o,
    output logic         skip_o,
    output logic         halt_o,
    output logic         rot_conflict_o
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         link;
        logic         skip;
        logic         halt;
        logic         rot_bad;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0] g1_acc, g2_acc;
    logic         g1_link, g1_bad, g2_skip, g2_halt;
    logic         is_opr, is_g2;

    assign is_opr = op_valid && (op_word[OPC_HI:OPC_LO] == OPC_OPERATE);
    assign is_g2  = op_word[GRP_BIT];

    opr_grp1 #(.W(W)) u_g1 (
        .mw        (op_word[7:0]),
        .acc_i     (st_q.acc),
        .link_i    (st_q.link),
        .acc_o     (g1_acc),
        .link_o    (g1_link),
        .rot_bad_o (g1_bad)
    );

    opr_grp2 #(.W(W)) u_g2 (
        .mw     (op_word[7:1]),
        .acc_i  (st_q.acc),
        .link_i (st_q.link),
        .sw_i   (switch_val),
        .acc_o  (g2_acc),
        .skip_o (g2_skip),
        .halt_o (g2_halt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.skip    = 1'b0;
        st_d.halt    = 1'b0;
        st_d.rot_bad = 1'b0;
        if (is_opr) begin
            if (!is_g2) begin
                st_d.acc     = g1_acc;
                st_d.link    = g1_link;
                st_d.rot_bad = g1_bad;
            end else if (!op_word[RSV_BIT]) begin
                st_d.acc  = g2_acc;
                st_d.skip = g2_skip;
                st_d.halt = g2_halt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o          = st_q.acc;
    assign link_o         = st_q.link;
    assign skip_o         = st_q.skip;
    assign halt_o         = st_q.halt;
    assign rot_conflict_o = st_q.rot_bad;

    p_idle_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_o) && $stable(link_o)));
    p_idle_flags_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!skip_o && !halt_o && !rot_conflict_o));
    p_g1_quiet_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_word[11:9] == 3'b111 && !op_word[8]) |=> (!skip_o && !halt_o));
    p_clr_inv_ones_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_word[11:8] == 4'b1110 && op_word[7] && op_word[5]
         && !op_word[0] && !op_word[3] && !op_word[2]) |=> (acc_o == '1));
    p_conflict_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_word[11:8] == 4'b1110 && op_word[3] && op_word[2]) |=> rot_conflict_o);
    p_g2_link_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_word[11:8] == 4'b1111) |=> $stable(link_o));
    p_halt_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_word[11:8] == 4'b1111 && !op_word[0] && op_word[1]) |=> halt_o);
    p_reserved_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_word[11:8] == 4'b1111 && op_word[0])
        |=> ($stable(acc_o) && !skip_o && !halt_o));
endmodule

// File: tb/opr_unit_test.sv
module opr_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [11:0] op_word;
    logic [11:0] switch_val;
    logic [11:0] acc_o;
    logic        link_o, skip_o, halt_o, rot_conflict_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [11:0] m_acc;
    logic        m_link, e_skip, e_halt, e_conf;

    always #(CLK_PERIOD/2) clk = ~clk;

    opr_unit #(.W(12)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
        .switch_val(switch_val), .acc_o(acc_o), .link_o(link_o),
        .skip_o(skip_o), .halt_o(halt_o), .rot_conflict_o(rot_conflict_o)
    );

    task automatic model(input logic [11:0] ir, input logic [11:0] sw);
        logic [12:0] v;
        logic [12:0] s;
        logic        hit;
        int          n;
        e_skip = 0; e_halt = 0; e_conf = 0;
        if (ir[11:9] != 3'b111) return;
        if (!ir[8]) begin
            if (ir[7]) m_acc = 0;
            if (ir[6]) m_link = 0;
            if (ir[5]) m_acc = ~m_acc;
            if (ir[4]) m_link = ~m_link;
            if (ir[0]) begin
                s = {1'b0, m_acc} + 13'd1;
                m_acc = s[11:0];
                if (s[12]) m_link = ~m_link;
            end
            v = {m_link, m_acc};
            n = ir[1] ? 2 : 1;
            if (ir[3] && ir[2]) e_conf = 1;
            else if (ir[3]) for (int i = 0; i < n; i++) v = {v[0], v[12:1]};
            else if (ir[2]) for (int i = 0; i < n; i++) v = {v[11:0], v[12]};
            m_link = v[12];
            m_acc  = v[11:0];
        end else if (!ir[0]) begin
            hit = (ir[6] && m_acc[11]) || (ir[5] && m_acc == 0) || (ir[4] && m_link);
            e_skip = hit ^ ir[3];
            if (ir[7]) m_acc = 0;
            if (ir[2]) m_acc = m_acc | sw;
            e_halt = ir[1];
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [11:0] act, input logic [11:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %o expected %o", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "acc", acc_o, m_acc);
        chk(tag, "link", {11'd0, link_o}, {11'd0, m_link});
        chk(tag, "skip", {11'd0, skip_o}, {11'd0, e_skip});
        chk(tag, "halt", {11'd0, halt_o}, {11'd0, e_halt});
        chk(tag, "conflict", {11'd0, rot_conflict_o}, {11'd0, e_conf});
    endtask

    // called at a falling edge; result checked at the next falling edge
    task automatic apply(input logic [11:0] ir, input logic [11:0] sw, input string tag);
        op_valid = 1; op_word = ir; switch_val = sw;
        model(ir, sw);
        @(negedge clk);
        op_valid = 0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        op_valid = 0; op_word = 12'o7777; switch_val = 12'o7777;
        e_skip = 0; e_halt = 0; e_conf = 0;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic set_state(input logic [11:0] a, input logic l);
        apply(12'o7604, a, "R8");          // clear then OR switches
        apply(12'o7100, 12'o0, "R4");      // clear link
        if (l) apply(12'o7020, 12'o0, "R4"); // complement link
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] seeds [4];
        logic [11:0] sws [4];
        seeds[0] = 12'o0000; seeds[1] = 12'o4000; seeds[2] = 12'o7777; seeds[3] = 12'o2525;
        sws[0]   = 12'o5252; sws[1]   = 12'o0017; sws[2]   = 12'o0000; sws[3]   = 12'o7400;
        rst_n = 0; op_valid = 0; op_word = 0; switch_val = 0;
        m_acc = 0; m_link = 0; e_skip = 0; e_halt = 0; e_conf = 0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1;
        @(negedge clk);
        compare("R1");

        // R3 group select
        set_state(12'o0000, 0);
        apply(12'o7001, 12'o0, "R3");
        apply(12'o7401, 12'o0, "R3 R10");

        // R4 ordering and carry
        set_state(12'o0005, 0);
        apply(12'o7041, 12'o0, "R4");      // negate: 7773
        apply(12'o7240, 12'o0, "R4");      // clear+complement: 7777
        set_state(12'o7777, 0);
        apply(12'o7001, 12'o0, "R4");      // wraps, link flips

        // R5 rotates
        set_state(12'o0001, 0);
        apply(12'o7010, 12'o0, "R5");
        set_state(12'o4000, 0);
        apply(12'o7006, 12'o0, "R5");
        apply(12'o7012, 12'o0, "R5");
        apply(12'o7002, 12'o0, "R5");      // twice bit alone

        // R6 conflict
        set_state(12'o0003, 1);
        apply(12'o7014, 12'o0, "R6");

        // R7 skip ordering and sense
        set_state(12'o0000, 0);
        apply(12'o7640, 12'o0, "R7");
        set_state(12'o4000, 0);
        apply(12'o7510, 12'o0, "R7");
        apply(12'o7410, 12'o0, "R7");

        // R8 switch OR, R9 halt, R10 reserved
        set_state(12'o0100, 1);
        apply(12'o7404, 12'o0003, "R8");
        apply(12'o7402, 12'o0, "R9");
        set_state(12'o1234, 0);
        apply(12'o7601, 12'o7777, "R10");
        apply(12'o7777, 12'o7777, "R10");

        // R2 ignored words and idle cycles
        apply(12'o1234, 12'o7777, "R2");
        apply(12'o6046, 12'o7777, "R2");
        idle("R2");
        idle("R2");

        // exhaustive group sweeps
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 256; k++) begin
                set_state(seeds[s], s[0]);
                apply({4'b1110, k[7:0]}, sws[s], "R4 R5 R6 R11");
            end
            for (int k = 0; k < 256; k++) begin
                set_state(seeds[s], s[1]);
                apply({4'b1111, k[7:0]}, sws[s], "R7 R8 R9 R10");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule